// File: doc/BRIEF.md
# DRAM Cycle Decoder with Parallel Test Mode

This block is a clocked model of the control side of an asynchronous, address-multiplexed DRAM. It runs inside a synchronous system, either as a checker next to a real memory interface or as the front end of an array model. The block registers the row strobe, column strobe, write strobe, address and data-in lines and detects edges on the registered strobes. It does not model analog timing: every decision depends only on the order in which sampled edges arrive.

Each row-strobe fall starts one cycle, and the block classifies it from the level of the column strobe at that moment. If the column strobe is high, the cycle is a normal access, and the access becomes a row-only refresh if no column strobe ever falls. If the column strobe is already low, the cycle is a counter-driven refresh. When that refresh follows a read with the column strobe still held low, it is a hidden refresh. The block keeps a refresh row counter and a parallel-test flag. It drives a data output together with its enable. It reaches a behavioural array through a port that carries a row, a 16-bit group index, a per-lane write mask and a returned 16-bit group word.

The control is one state machine with three states:
- `ST_IDLE`: the row strobe is high.
- `ST_ACCESS`: a row opened by an external address.
- `ST_REFRESH`: a row opened by the counter.

It has four transitions:
- `T_ACT`: `ST_IDLE` to `ST_ACCESS`, on a row-strobe fall with the column strobe high.
- `T_CBR`: `ST_IDLE` to `ST_REFRESH`, on a row-strobe fall with the column strobe low.
- `T_CLOSE`: `ST_ACCESS` to `ST_IDLE`, on a row-strobe rise.
- `T_REF_END`: `ST_REFRESH` to `ST_IDLE`, on a row-strobe rise.

Top module: `dram_cycle_decoder`

## Requirements
- R1: A row-strobe fall sampled with the column strobe low pulses `arr_act` with `arr_row` equal to the refresh counter and ignores `addr`. The counter then increments and wraps from 4095 to 0.
- R2: A row-strobe fall sampled with the column strobe high pulses `arr_act` with `arr_row` equal to `addr`. If no column-strobe fall arrives before the row strobe rises, `q_oe` stays low for the whole cycle.
- R3: If the column strobe stays low after a read while the row strobe rises and falls again, that fall is a counter refresh (R1). `q_oe` stays high and `q` holds the read value until the column strobe rises.
- R4: A counter refresh with `we_n` low sets test mode, and that entry cycle still refreshes. A counter refresh with `we_n` high clears test mode, and so does a row-only refresh (R2).
- R5: The column splits into group = col[9:2] and lane = {col[11:10], col[1:0]}. A normal write sets only mask bit `lane`. A test-mode write sets all 16 mask bits, so `din` lands in all 16 lanes.
- R6: A test-mode read returns 1 when all 16 bits of the group word are equal and 0 when any bit differs. A normal read returns bit `lane` of the word.
- R7: A column-strobe fall with `we_n` high (a read) raises `q_oe` at the second rising clock edge after the new input levels are presented. A column-strobe rise lowers `q_oe` with the same latency. A column-strobe fall with `we_n` low (early write) never raises `q_oe`.
- R8: A `we_n` fall while the column strobe is already low within an access writes `din` to the column latched at the column-strobe fall.
- R9: After reset, the counter is 0, test mode is off, `q_oe` is low and no array strobe is active.
- R10: Several column-strobe cycles within one row-strobe low period read and write different columns of the same row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 12 | Multiplexed row/column address |
| din | input | 1 | Write data bit |
| q | output | 1 | Read data, or the compare result in test mode |
| q_oe | output | 1 | Output drive enable (low means high impedance) |
| arr_act | output | 1 | Row activation (refresh) pulse |
| arr_row | output | 12 | Row presented to the array |
| arr_grp | output | 8 | 16-bit group index within the row |
| arr_rd | output | 1 | Group read strobe |
| arr_wr | output | 1 | Group write strobe |
| arr_wmask | output | 16 | Lane write mask |
| arr_wbit | output | 1 | Bit written to the masked lanes |
| arr_rword | input | 16 | Group word returned by the array |

## Verification
The embedded assertions check, on every cycle, the properties that concern output enable and state:
- a high column strobe forces the output off on the next cycle;
- an early write keeps the output off;
- a hidden refresh keeps the output and its value unchanged;
- a row-only access that has seen no column fall leaves the output off;
- a row-only refresh clears test mode;
- each counter refresh advances the counter by one;
- every write mask is either one-hot or all ones.

Data correctness cannot be checked that way and is left to the bench scenarios:
- data written in page mode and by a delayed write;
- the all-equal compare over 16 lanes after a lane has been disturbed;
- the rows chosen across a wrap of the refresh counter.

// File: rtl/dramdec_pkg.sv
package dramdec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_REFRESH = 2'd2
    } dd_state_e;
endpackage

// File: rtl/dramdec_sync.sv
// Registers the asynchronous strobes and lines, and flags edges on the
// registered strobes.
module dramdec_sync #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic          din,
    output logic          ras_s,
    output logic          cas_s,
    output logic          we_s,
    output logic [AW-1:0] addr_s,
    output logic          din_s,
    output logic          ras_fall,
    output logic          ras_rise,
    output logic          cas_fall,
    output logic          we_fall
);
    logic ras_p, cas_p, we_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_s  <= 1'b1;
            cas_s  <= 1'b1;
            we_s   <= 1'b1;
            ras_p  <= 1'b1;
            cas_p  <= 1'b1;
            we_p   <= 1'b1;
            addr_s <= '0;
            din_s  <= 1'b0;
        end else begin
            ras_s  <= ras_n;
            cas_s  <= cas_n;
            we_s   <= we_n;
            ras_p  <= ras_s;
            cas_p  <= cas_s;
            we_p   <= we_s;
            addr_s <= addr;
            din_s  <= din;
        end
    end

    assign ras_fall = ras_p & ~ras_s;
    assign ras_rise = ~ras_p & ras_s;
    assign cas_fall = cas_p & ~cas_s;
    assign we_fall  = we_p & ~we_s;
endmodule

// File: rtl/dramdec_refcnt.sv
// Internal refresh row counter; wraps naturally at 2**W.
module dramdec_refcnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (adv) cnt <= cnt + 1'b1;
    end

    // R1: each counter refresh steps the row by exactly one (modulo width)
    a_r1_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (cnt == W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/dramdec_lane.sv
// Splits a column into group index and lane, builds the write mask and
// reduces the returned group word to one output bit.
module dramdec_lane #(
    parameter int COL_W = 12,
    parameter int LANES = 16
) (
    input  logic [COL_W-1:0]                   col,
    input  logic                               tm,
    input  logic [LANES-1:0]                   rword,
    output logic [COL_W-$clog2(LANES)-1:0]     grp,
    output logic [LANES-1:0]                   wmask,
    output logic                               rbit
);
    localparam int LANE_W = $clog2(LANES);
    localparam int HALF   = LANE_W / 2;

    logic [LANE_W-1:0] lane;

    assign lane = {col[COL_W-1 -: (LANE_W-HALF)], col[HALF-1:0]};
    assign grp  = col[COL_W-(LANE_W-HALF)-1 : HALF];

    for (genvar i = 0; i < LANES; i++) begin : g_mask
        assign wmask[i] = tm | (lane == LANE_W'(i));
    end

    assign rbit = tm ? ((&rword) | ~(|rword)) : rword[lane];

    // R5: a write mask is one lane, or every lane in test mode
    always_comb begin
        a_r5_mask_shape: assert (($countones(wmask) == 1) || (&wmask));
    end
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dramdec_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 12,
    parameter int LANES = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ras_n,
    input  logic                               cas_n,
    input  logic                               we_n,
    input  logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr,
    input  logic                               din,
    output logic                               q,
    output logic                               q_oe,
    output logic                               arr_act,
    output logic [ROW_W-1:0]                   arr_row,
    output logic [COL_W-$clog2(LANES)-1:0]     arr_grp,
    output logic                               arr_rd,
    output logic                               arr_wr,
    output logic [LANES-1:0]                   arr_wmask,
    output logic                               arr_wbit,
    input  logic [LANES-1:0]                   arr_rword
);
    localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W;

    logic          ras_s, cas_s, we_s, din_s;
    logic [AW-1:0] addr_s;
    logic          ras_fall, ras_rise, cas_fall, we_fall;

    dd_state_e         state, state_nx;
    logic [ROW_W-1:0]  row_r, cnt;
    logic [COL_W-1:0]  col_r, col_sel;
    logic              cas_seen, tm, q_r, rbit;
    logic              cbr_go, acc_cas_fall, dly_wr;

    dramdec_sync #(.AW(AW)) u_sync (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .ras_s(ras_s), .cas_s(cas_s), .we_s(we_s),
        .addr_s(addr_s), .din_s(din_s), .ras_fall(ras_fall),
        .ras_rise(ras_rise), .cas_fall(cas_fall), .we_fall(we_fall)
    );

    assign cbr_go = (state == ST_IDLE) && ras_fall && !cas_s;

    dramdec_refcnt #(.W(ROW_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .adv(cbr_go), .cnt(cnt)
    );

    // Column strobe events and writes inside an externally addressed row
    assign acc_cas_fall = (state == ST_ACCESS) && cas_fall;
    assign dly_wr       = (state == ST_ACCESS) && we_fall && !cas_s && !cas_fall;
    assign col_sel      = acc_cas_fall ? addr_s[COL_W-1:0] : col_r;

    dramdec_lane #(.COL_W(COL_W), .LANES(LANES)) u_lane (
        .col(col_sel), .tm(tm), .rword(arr_rword),
        .grp(arr_grp), .wmask(arr_wmask), .rbit(rbit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state: T_ACT, T_CBR, T_CLOSE, T_REF_END
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ras_fall) state_nx = cas_s ? ST_ACCESS : ST_REFRESH;
            end
            ST_ACCESS: begin
                if (ras_rise) state_nx = ST_IDLE;
            end
            ST_REFRESH: begin
                if (ras_rise) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Array strobes
    always_comb begin
        arr_act  = (state == ST_IDLE) && ras_fall;
        arr_row  = arr_act ? (cas_s ? addr_s[ROW_W-1:0] : cnt) : row_r;
        arr_rd   = acc_cas_fall && we_s;
        arr_wr   = (acc_cas_fall && !we_s) || dly_wr;
        arr_wbit = din_s;
    end

    // Output and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_r    <= '0;
            col_r    <= '0;
            cas_seen <= 1'b0;
            tm       <= 1'b0;
            q_r      <= 1'b0;
            q_oe     <= 1'b0;
        end else begin
            if (arr_act) row_r <= arr_row;
            if (state == ST_IDLE && ras_fall) begin
                cas_seen <= 1'b0;
                if (!cas_s) tm <= !we_s;
            end
            if (state == ST_ACCESS && ras_rise && !cas_seen) tm <= 1'b0;
            if (acc_cas_fall) begin
                col_r    <= addr_s[COL_W-1:0];
                cas_seen <= 1'b1;
            end
            if (arr_rd) q_r <= rbit;
            if (cas_s)       q_oe <= 1'b0;
            else if (arr_rd) q_oe <= 1'b1;
        end
    end

    assign q = q_r;

    // R7: a high column strobe turns the output off next cycle
    a_r7_hiz_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
        cas_s |=> !q_oe);
    // R7: an early write leaves the output off
    a_r7_early_write_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_fall && !we_s) |=> !q_oe);
    // R2: an access with no column fall yet never drives the output
    a_r2_ror_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && !cas_seen) |-> !q_oe);
    // R4: a row-only refresh leaves test mode
    a_r4_ror_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && ras_rise && !cas_seen) |=> !tm);
    // R3: a hidden refresh keeps the driven read value
    a_r3_hidden_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cbr_go && q_oe) |=> (q_oe && $stable(q_r)));
    // R8: reads and writes never coincide
    a_r8_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_rd, arr_wr}));
endmodule

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ras_n, cas_n, we_n, din;
    logic [11:0] addr;
    logic        q, q_oe, arr_act, arr_rd, arr_wr, arr_wbit;
    logic [11:0] arr_row;
    logic [7:0]  arr_grp;
    logic [15:0] arr_wmask, arr_rword;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dram_cycle_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .q(q), .q_oe(q_oe), .arr_act(arr_act),
        .arr_row(arr_row), .arr_grp(arr_grp), .arr_rd(arr_rd), .arr_wr(arr_wr),
        .arr_wmask(arr_wmask), .arr_wbit(arr_wbit), .arr_rword(arr_rword)
    );

    // Behavioural array behind the port
    logic [15:0] env_mem [int];
    int          env_key;
    logic [15:0] env_old;
    always @(posedge clk) begin
        if (arr_wr) begin
            env_key = int'(arr_row) * 256 + int'(arr_grp);
            env_old = env_mem.exists(env_key) ? env_mem[env_key] : 16'h0;
            env_mem[env_key] = (env_old & ~arr_wmask) | ({16{arr_wbit}} & arr_wmask);
        end
    end
    always @(negedge clk) begin
        env_key   = int'(arr_row) * 256 + int'(arr_grp);
        arr_rword = env_mem.exists(env_key) ? env_mem[env_key] : 16'h0;
    end

    // Reference model state
    bit    ref_mem [int];
    bit    m_ras = 1, m_cas = 1, m_we = 1;
    int    m_mode = 0;
    bit    m_seen = 0, m_tm = 0, m_oe = 0, m_q = 0;
    int    m_cnt = 0, m_row = 0, m_col = 0;
    string cur_req = "R9";

    bit    e_oe[$], e_q[$], e_act[$];
    int    e_row[$];
    string e_req[$];

    function automatic int tm_col(int c, int l);
        return (((l >> 2) & 3) << 10) | (c & 12'h3FC) | (l & 3);
    endfunction

    function automatic bit rd_bit(int key);
        return ref_mem.exists(key) ? ref_mem[key] : 1'b0;
    endfunction

    function automatic void mem_write(bit d);
        if (m_tm) begin
            for (int l = 0; l < 16; l++) ref_mem[m_row * 4096 + tm_col(m_col, l)] = d;
        end else begin
            ref_mem[m_row * 4096 + m_col] = d;
        end
    endfunction

    function automatic bit mem_read();
        int ones = 0;
        if (!m_tm) return rd_bit(m_row * 4096 + m_col);
        for (int l = 0; l < 16; l++) ones += rd_bit(m_row * 4096 + tm_col(m_col, l));
        return (ones == 0) || (ones == 16);
    endfunction

    task automatic model_step();
        bit rf = m_ras && !ras_n;
        bit rr = !m_ras && ras_n;
        bit cf = m_cas && !cas_n;
        bit wf = m_we && !we_n;
        bit act = 0;
        int arow = 0;
        if (rst_n) begin
            if (m_mode == 0 && rf) begin
                act = 1;
                if (!cas_n) begin
                    arow = m_cnt; m_cnt = (m_cnt + 1) % 4096; m_tm = !we_n; m_mode = 2;
                end else begin
                    arow = int'(addr); m_row = int'(addr); m_seen = 0; m_mode = 1;
                end
            end else if (m_mode == 1) begin
                if (rr) begin
                    if (!m_seen) m_tm = 0;
                    m_mode = 0;
                end else if (cf) begin
                    m_col = int'(addr); m_seen = 1;
                    if (!we_n) mem_write(din);
                    else begin m_q = mem_read(); m_oe = 1; end
                end else if (wf && !cas_n) begin
                    mem_write(din);
                end
            end else if (m_mode == 2 && rr) begin
                m_mode = 0;
            end
            if (cas_n) m_oe = 0;
        end
        m_ras = ras_n; m_cas = cas_n; m_we = we_n;
        e_oe.push_back(m_oe); e_q.push_back(m_q); e_act.push_back(act);
        e_row.push_back(arow); e_req.push_back(cur_req);
    endtask

    task automatic chk(string req, string what, int act_v, int exp_v);
        tests++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act_v, exp_v, $time);
        end
    endtask

    // Outputs now reflect inputs driven two steps ago (q_oe, q) or one step ago (array strobes)
    task automatic compare();
        chk(e_req[1], "q_oe", int'(q_oe), int'(e_oe[1]));
        if (e_oe[1]) chk(e_req[1], "q", int'(q), int'(e_q[1]));
        chk(e_req[2], "arr_act", int'(arr_act), int'(e_act[2]));
        if (e_act[2]) chk(e_req[2], "arr_row", int'(arr_row), e_row[2]);
        void'(e_oe.pop_front()); void'(e_q.pop_front()); void'(e_act.pop_front());
        void'(e_row.pop_front()); void'(e_req.pop_front());
    endtask

    task automatic step(logic r, logic c, logic w, int a, logic d);
        ras_n = r; cas_n = c; we_n = w; addr = a[11:0]; din = d;
        model_step();
        compare();
        @(negedge clk);
    endtask

    task automatic open_row(int r);
        step(1, 1, 1, r, 0);
        step(0, 1, 1, r, 0);
        step(0, 1, 1, r, 0);
    endtask
    task automatic close_row();
        step(1, 1, 1, 0, 0);
        step(1, 1, 1, 0, 0);
    endtask
    task automatic early_write(int c, logic d);
        step(0, 1, 0, c, d);
        step(0, 0, 0, c, d);
        step(0, 0, 0, c, d);
        step(0, 1, 1, c, d);
    endtask
    task automatic page_read(int c);
        step(0, 0, 1, c, 0);
        step(0, 0, 1, c, 0);
        step(0, 0, 1, c, 0);
        step(0, 0, 1, c, 0);
        step(0, 1, 1, c, 0);
        step(0, 1, 1, c, 0);
    endtask
    task automatic cbr(logic w, int junk);
        step(1, 0, w, junk, 0);
        step(0, 0, w, junk, 0);
        step(0, 0, w, junk, 0);
        step(1, 0, w, junk, 0);
        step(1, 1, 1, junk, 0);
    endtask
    task automatic ror(int r);
        open_row(r);
        step(0, 1, 1, r, 0);
        close_row();
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            e_oe.push_back(0); e_q.push_back(0); e_act.push_back(0);
            e_row.push_back(0); e_req.push_back("R9");
        end
        rst_n = 0; ras_n = 1; cas_n = 1; we_n = 1; addr = 0; din = 0;
        @(negedge clk);
        step(1, 1, 1, 0, 0);
        step(1, 1, 1, 0, 0);
        // R9: reset state
        chk("R9", "q_oe after reset", int'(q_oe), 0);
        chk("R9", "arr_wr after reset", int'(arr_wr), 0);
        rst_n = 1;
        step(1, 1, 1, 0, 0);

        // R10 / R7: page-mode early writes, then page-mode reads on row 5
        cur_req = "R10";
        open_row(5);
        early_write(12'h013, 1);
        early_write(12'h8A2, 0);
        early_write(12'h440, 1);
        close_row();
        open_row(5);
        page_read(12'h013);
        page_read(12'h8A2);
        page_read(12'h440);
        close_row();

        // R2: row-only refresh keeps the output off and uses the address row
        cur_req = "R2";
        ror(12'h9C3);

        // R8: delayed write after a read of the same column
        cur_req = "R8";
        open_row(7);
        step(0, 0, 1, 12'h055, 1);
        step(0, 0, 1, 12'h055, 1);
        step(0, 0, 1, 12'h055, 1);
        step(0, 0, 0, 12'h000, 1);
        step(0, 0, 0, 12'h000, 1);
        step(0, 1, 1, 12'h000, 0);
        step(0, 1, 1, 12'h000, 0);
        page_read(12'h055);
        close_row();

        // R3: hidden refresh after a read of a 1
        cur_req = "R3";
        open_row(5);
        step(0, 0, 1, 12'h013, 0);
        step(0, 0, 1, 12'h013, 0);
        step(0, 0, 1, 12'h013, 0);
        step(1, 0, 1, 12'h777, 0);
        step(1, 0, 1, 12'h777, 0);
        step(0, 0, 1, 12'h777, 0);
        step(0, 0, 1, 12'h777, 0);
        step(0, 0, 1, 12'h777, 0);
        step(1, 0, 1, 12'h777, 0);
        step(1, 1, 1, 12'h777, 0);
        step(1, 1, 1, 12'h777, 0);

        // R4 / R5 / R6: test-mode entry, parallel write and compare
        cur_req = "R4";
        cbr(0, 12'hABC);
        cur_req = "R5";
        open_row(20);
        early_write(12'h124, 1);
        close_row();
        cur_req = "R6";
        open_row(20);
        page_read(12'hD27);
        close_row();
        cur_req = "R4";
        cbr(1, 12'h001);
        cur_req = "R5";
        open_row(20);
        early_write(12'h125, 0);
        page_read(12'hC24);
        page_read(12'h125);
        close_row();
        cur_req = "R4";
        cbr(0, 12'h002);
        cur_req = "R6";
        open_row(20);
        page_read(12'h124);
        close_row();
        cur_req = "R4";
        ror(12'h020);
        open_row(20);
        page_read(12'h126);
        close_row();

        // R1: counter refreshes across the wrap
        cur_req = "R1";
        for (int i = 0; i < 4100; i++) cbr(1, i);

        step(1, 1, 1, 0, 0);
        step(1, 1, 1, 0, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule